// File: doc/BRIEF.md
# Floating-Point Control and Status Register Block

This block holds the two architectural registers that govern floating-point behaviour in a small processor. Software reaches them through an auxiliary register port, with a combinational read and a write that takes effect on the clock edge. The control register holds the rounding mode, which is driven straight to the FP datapath, and two trap-enable bits. The status register keeps five sticky exception flags.

The FP datapath reports each completed instruction through a completion strobe and a 5-bit exception vector. These bits are ORed into the status flags. If an invalid-operation or divide-by-zero event arrives while its enable bit is set, the block raises a one-cycle trap request. The flag is recorded in either case.

Software can clear or set the flags directly, but only in a store that also sets bit 31 of the written value. That bit acts as a one-shot write permission. It is never stored.

Top module: `fpcsr_top`

## Requirements
- R1: After reset, the control register reads 0x00000100, the status register reads 0x00000000, `rnd_mode_o` is 2'b01 and `trap_req_o` is 0.
- R2: A write to address 0x300 stores bit 0 (invalid-trap enable), bit 1 (divide-by-zero trap enable) and bits [9:8] (rounding mode). All other control bits read as zero. From the next cycle, `rnd_mode_o` equals the stored bits [9:8]: 00 toward zero, 01 nearest, 10 toward +inf, 11 toward -inf.
- R3: When `fp_done_i` is 1, `fp_flags_i` is ORed into the status flags at the clock edge. The flags sit at bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow and bit 4 inexact. When `fp_done_i` is 0, `fp_flags_i` has no effect.
- R4: A write to address 0x301 whose data bit 31 is 1 replaces flags [4:0] with data bits [4:0]. Such a write can clear flags.
- R5: A write to address 0x301 whose data bit 31 is 0 leaves the flags unchanged.
- R6: Bit 31 and bits [30:5] of the status register always read as zero.
- R7: If a permitted status write and an FP completion fall in the same cycle, the flags become the written bits [4:0] ORed with `fp_flags_i`.
- R8: A completion that reports invalid with control bit 0 set, or divide-by-zero with control bit 1 set, makes `trap_req_o` 1 for exactly the following cycle. The flag is still recorded.
- R9: A completion that reports invalid or divide-by-zero while the matching enable bit is 0 sets the flag only and raises no trap request.
- R10: A read of any address other than 0x300 or 0x301 returns zero. A write to such an address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| aux_addr_i | input | AUX_AW | Auxiliary register address |
| aux_wr_i | input | 1 | Write strobe |
| aux_wdata_i | input | 32 | Write data |
| aux_rdata_o | output | 32 | Combinational read data for aux_addr_i |
| fp_done_i | input | 1 | FP instruction completion strobe |
| fp_flags_i | input | 5 | Exception vector of the completing instruction |
| rnd_mode_o | output | 2 | Rounding mode to the FP datapath |
| trap_req_o | output | 1 | One-cycle trap request |

## Verification
A permitted direct flag write and an FP completion can fall in the same cycle, and so can the corresponding update of the flags. The bench provokes this by driving a status store that has bit 31 set at the same edge as a completion strobe, with the written flags and the reported flags chosen to be disjoint. The result counts as correct only if the read-back holds the union of both vectors, which proves that neither source masked the other. Separately, a trap-enabled completion is checked to raise the trap and to record its flag at the same edge.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int DW       = 32;
  localparam int NFLAG    = 5;
  localparam int NTRAP    = 2;
  localparam int RM_LSB   = 8;
  localparam int WPERM_B  = 31;
  localparam int FL_INV   = 0;
  localparam int FL_DZ    = 1;

  typedef enum logic [1:0] {
    RND_ZERO = 2'b00,
    RND_NEAR = 2'b01,
    RND_PINF = 2'b10,
    RND_MINF = 2'b11
  } rnd_mode_e;

  typedef struct packed {
    rnd_mode_e        rnd;
    logic [NTRAP-1:0] trap_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{rnd: RND_NEAR, trap_en: '0};
endpackage

// File: rtl/fpcsr_ctrl_reg.sv
module fpcsr_ctrl_reg
  import fpcsr_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [NTRAP-1:0]      trap_en_o,
  output rnd_mode_e             rnd_o,
  output logic [DW-1:0]         rdata_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (we_i) begin
      ctrl_q.trap_en <= wdata_i[NTRAP-1:0];
      ctrl_q.rnd     <= rnd_mode_e'(wdata_i[RM_LSB+1:RM_LSB]);
    end
  end

  always_comb begin
    rdata_o                    = '0;
    rdata_o[NTRAP-1:0]         = ctrl_q.trap_en;
    rdata_o[RM_LSB+1:RM_LSB]   = ctrl_q.rnd;
  end

  assign trap_en_o = ctrl_q.trap_en;
  assign rnd_o     = ctrl_q.rnd;
endmodule

// File: rtl/fpcsr_flag_reg.sv
module fpcsr_flag_reg
  import fpcsr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             upd_i,
  input  logic [NFLAG-1:0] upd_flags_i,
  output logic [NFLAG-1:0] flags_o,
  output logic [DW-1:0]    rdata_o
);
  logic [NFLAG-1:0] flags_q, hw_set, base;
  logic             sw_wr;

  // software write needs the one-shot permission bit in the same store
  assign sw_wr  = we_i & wdata_i[WPERM_B];
  assign hw_set = upd_i ? upd_flags_i : '0;
  assign base   = sw_wr ? wdata_i[NFLAG-1:0] : flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= base | hw_set;
  end

  always_comb begin
    rdata_o            = '0;
    rdata_o[NFLAG-1:0] = flags_q;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/fpcsr_trap_gen.sv
module fpcsr_trap_gen
  import fpcsr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [NFLAG-1:0] upd_flags_i,
  input  logic [NTRAP-1:0] en_i,
  output logic             trap_o
);
  // trappable flags occupy the low NTRAP positions, matching the enables
  logic [NTRAP-1:0] hit;
  logic             trap_q;

  for (genvar g = 0; g < NTRAP; g++) begin : g_src
    assign hit[g] = upd_i & upd_flags_i[g] & en_i[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trap_q <= 1'b0;
    else         trap_q <= |hit;
  end

  assign trap_o = trap_q;
endmodule

// File: rtl/fpcsr_top.sv
module fpcsr_top
  import fpcsr_pkg::*;
#(
  parameter int              AUX_AW    = 12,
  parameter logic [AUX_AW-1:0] CTRL_ADDR = 12'h300,
  parameter logic [AUX_AW-1:0] STAT_ADDR = 12'h301
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AUX_AW-1:0] aux_addr_i,
  input  logic              aux_wr_i,
  input  logic [31:0]       aux_wdata_i,
  output logic [31:0]       aux_rdata_o,
  input  logic              fp_done_i,
  input  logic [4:0]        fp_flags_i,
  output logic [1:0]        rnd_mode_o,
  output logic              trap_req_o
);
  logic             sel_ctrl, sel_stat;
  logic [DW-1:0]    ctrl_rdata, stat_rdata;
  logic [NTRAP-1:0] trap_en;
  logic [NFLAG-1:0] flags;
  rnd_mode_e        rnd;

  assign sel_ctrl = (aux_addr_i == CTRL_ADDR);
  assign sel_stat = (aux_addr_i == STAT_ADDR);

  fpcsr_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (aux_wr_i & sel_ctrl),
    .wdata_i   (aux_wdata_i),
    .trap_en_o (trap_en),
    .rnd_o     (rnd),
    .rdata_o   (ctrl_rdata)
  );

  fpcsr_flag_reg u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (aux_wr_i & sel_stat),
    .wdata_i     (aux_wdata_i),
    .upd_i       (fp_done_i),
    .upd_flags_i (fp_flags_i),
    .flags_o     (flags),
    .rdata_o     (stat_rdata)
  );

  fpcsr_trap_gen u_trap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_i       (fp_done_i),
    .upd_flags_i (fp_flags_i),
    .en_i        (trap_en),
    .trap_o      (trap_req_o)
  );

  always_comb begin
    unique case (1'b1)
      sel_ctrl: aux_rdata_o = ctrl_rdata;
      sel_stat: aux_rdata_o = stat_rdata;
      default:  aux_rdata_o = '0;
    endcase
  end

  assign rnd_mode_o = rnd;
endmodule

// File: rtl/fpcsr_checker.sv
module fpcsr_checker #(
  parameter int                AUX_AW    = 12,
  parameter logic [AUX_AW-1:0] CTRL_ADDR = 12'h300,
  parameter logic [AUX_AW-1:0] STAT_ADDR = 12'h301
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AUX_AW-1:0] aux_addr_i,
  input logic              aux_wr_i,
  input logic [31:0]       aux_wdata_i,
  input logic [31:0]       aux_rdata_o,
  input logic              fp_done_i,
  input logic [4:0]        fp_flags_i,
  input logic [1:0]        rnd_mode_o,
  input logic              trap_req_o,
  input logic [1:0]        trap_en,
  input logic [4:0]        flags
);
  logic perm_wr;
  assign perm_wr = aux_wr_i && aux_addr_i == STAT_ADDR && aux_wdata_i[31];

  assert_rnd_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_wr_i && aux_addr_i == CTRL_ADDR) |=> rnd_mode_o == $past(aux_wdata_i[9:8]));

  assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perm_wr |=> (flags & $past(flags)) == $past(flags));

  assert_no_wperm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!perm_wr && !fp_done_i) |=> $stable(flags));

  assert_top_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_addr_i == STAT_ADDR |-> aux_rdata_o[31:5] == '0);

  assert_merge_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perm_wr && fp_done_i) |=> flags == ($past(aux_wdata_i[4:0]) | $past(fp_flags_i)));

  assert_trap_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> $past(fp_done_i && ((fp_flags_i[0] && trap_en[0]) ||
                                       (fp_flags_i[1] && trap_en[1]))));

  assert_no_trap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_done_i && trap_en == 2'b00) |=> !trap_req_o);

  assert_unmapped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aux_addr_i != CTRL_ADDR && aux_addr_i != STAT_ADDR) |-> aux_rdata_o == '0);
endmodule

bind fpcsr_top fpcsr_checker #(
  .AUX_AW(AUX_AW), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .aux_addr_i(aux_addr_i), .aux_wr_i(aux_wr_i),
  .aux_wdata_i(aux_wdata_i), .aux_rdata_o(aux_rdata_o), .fp_done_i(fp_done_i),
  .fp_flags_i(fp_flags_i), .rnd_mode_o(rnd_mode_o), .trap_req_o(trap_req_o),
  .trap_en(trap_en), .flags(flags)
);

// File: tb/fpcsr_top_bench.sv
`timescale 1ns/1ps
module fpcsr_top_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] aux_addr_i = '0;
  logic        aux_wr_i = 1'b0;
  logic [31:0] aux_wdata_i = '0;
  logic [31:0] aux_rdata_o;
  logic        fp_done_i = 1'b0;
  logic [4:0]  fp_flags_i = '0;
  logic [1:0]  rnd_mode_o;
  logic        trap_req_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  fpcsr_top u_fpcsr_top (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
    end
  endtask

  // drive one cycle of stimulus at negedge, return at the following negedge
  task automatic cyc(input logic [11:0] a, input logic wr, input logic [31:0] wd,
                     input logic dn, input logic [4:0] fl);
    @(negedge clk_i);
    aux_addr_i = a; aux_wr_i = wr; aux_wdata_i = wd; fp_done_i = dn; fp_flags_i = fl;
    @(negedge clk_i);
    aux_wr_i = 1'b0; fp_done_i = 1'b0; fp_flags_i = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    aux_addr_i = a;
    #1 d = aux_rdata_o;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h300, d); check("R1 ctrl", d, 32'h100);
    rd(12'h301, d); check("R1 stat", d, 32'h0);
    check("R1 rnd", {30'b0, rnd_mode_o}, 32'h1);
    check("R1 trap", {31'b0, trap_req_o}, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    cyc(12'h300, 1, 32'hFFFF_FFFF, 0, 0);
    rd(12'h300, d); check("R2 mask", d, 32'h303);
    check("R2 rnd 11", {30'b0, rnd_mode_o}, 32'h3);
    cyc(12'h300, 1, 32'h0000_0200, 0, 0);
    check("R2 rnd 10", {30'b0, rnd_mode_o}, 32'h2);
    cyc(12'h300, 1, 32'h0, 0, 0);
    check("R2 rnd 00", {30'b0, rnd_mode_o}, 32'h0);
    cyc(12'h300, 1, 32'h100, 0, 0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    cyc(12'h000, 0, 0, 1, 5'h04);
    rd(12'h301, d); check("R3 ov", d, 32'h04);
    cyc(12'h000, 0, 0, 1, 5'h10);
    rd(12'h301, d); check("R3 accumulate", d, 32'h14);
    cyc(12'h000, 0, 0, 0, 5'h1F);
    rd(12'h301, d); check("R3 no strobe", d, 32'h14);
  endtask

  task automatic t_swwrite();
    logic [31:0] d;
    cyc(12'h301, 1, 32'h0000_001F, 0, 0);
    rd(12'h301, d); check("R5 no perm", d, 32'h14);
    cyc(12'h301, 1, 32'h8000_0003, 0, 0);
    rd(12'h301, d); check("R4 replace", d, 32'h03);
    check("R6 bit31", {31'b0, d[31]}, 32'h0);
    cyc(12'h301, 1, 32'hFFFF_FFE0, 0, 0);
    rd(12'h301, d); check("R6 upper bits", d, 32'h0);
  endtask

  task automatic t_merge();
    logic [31:0] d;
    cyc(12'h301, 1, 32'h8000_0001, 1, 5'h08);
    rd(12'h301, d); check("R7 merge", d, 32'h09);
    cyc(12'h301, 1, 32'h8000_0000, 0, 0);
  endtask

  task automatic t_trap();
    logic [31:0] d;
    cyc(12'h300, 1, 32'h103, 0, 0);
    @(negedge clk_i);
    aux_addr_i = 12'h301; fp_done_i = 1; fp_flags_i = 5'h01;
    @(negedge clk_i);
    fp_done_i = 0; fp_flags_i = '0;
    #1 check("R8 pulse", {31'b0, trap_req_o}, 32'h1);
    check("R8 flag kept", aux_rdata_o, 32'h01);
    @(negedge clk_i);
    #1 check("R8 one cycle", {31'b0, trap_req_o}, 32'h0);
    cyc(12'h301, 1, 32'h8000_0000, 0, 0);
    cyc(12'h301, 0, 0, 1, 5'h02);
    #1 check("R8 dz pulse", {31'b0, trap_req_o}, 32'h1);
  endtask

  task automatic t_notrap();
    logic [31:0] d;
    cyc(12'h300, 1, 32'h100, 0, 0);
    cyc(12'h301, 1, 32'h8000_0000, 0, 0);
    cyc(12'h301, 0, 0, 1, 5'h03);
    #1 check("R9 no trap", {31'b0, trap_req_o}, 32'h0);
    rd(12'h301, d); check("R9 flags", d, 32'h03);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    cyc(12'h302, 1, 32'hFFFF_FFFF, 0, 0);
    rd(12'h302, d); check("R10 read zero", d, 32'h0);
    cyc(12'h2FF, 1, 32'h8000_0000, 0, 0);
    rd(12'h300, d); check("R10 ctrl kept", d, 32'h100);
    rd(12'h301, d); check("R10 stat kept", d, 32'h03);
  endtask

  initial begin
    #20 rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ctrl();
    t_sticky();
    t_swwrite();
    t_merge();
    t_trap();
    t_notrap();
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule